// File: doc/BRIEF.md
# ATM Cell Bus Ingress Framer

This block sits on the physical-layer side of a cell bus. An ATM layer device writes cells into it, one byte or one 16-bit word per clock. A transfer counts only in a cycle where the active-low write enable is low. A one-clock start-of-cell pulse, given together with the first transfer, arms the block. The block then accepts exactly one cell of transfers and ignores the bus until the next pulse. Odd parity, supplied on a separate input, is checked on every transfer the block accepts.

Accepted transfers go into a cell buffer. The buffer commits a cell only when its last transfer has arrived. Finished cells leave in order on a write-only output port that carries start and end markers. A start-of-cell pulse that arrives while a cell is still open marks that partial cell as a runt. The block rolls the runt back out of the buffer and raises an alignment interrupt. The data word that came with that pulse becomes the first transfer of a new cell.

Top module: `cellbus_ingress`

## Requirements
- R1: While reset is asserted and on release, `out_valid`, `irq_align` and `par_err` are 0.
- R2: A cycle with `bus_wen_n` high is not a transfer. Data, parity and start-of-cell presented in that cycle have no effect.
- R3: Transfers that arrive while no cell is open are discarded. A transfer with `bus_soc` high always opens a new cell and becomes its first entry.
- R4: `cfg_len_sel` selects the cell length: 0 gives 52 bytes, 1 gives 53 bytes, 2 or 3 gives 54 bytes. In byte mode (`cfg_wide`=0) a cell has that many transfers. In word mode (`cfg_wide`=1) it has half that number rounded up: 26, 27 or 27.
- R5: Once a cell has received its full count of transfers, further transfers without `bus_soc` are discarded.
- R6: A `bus_soc` transfer while a cell is open discards the partial cell entirely. `irq_align` is then high for the one cycle after that clock edge, and the new cell starts with the data of that transfer.
- R7: Only complete cells appear on the output, in arrival order and each contiguous. `out_sop` marks the first word and `out_eop` the last.
- R8: In byte mode `bus_data[15:8]` is ignored and `out_data[15:8]` is 0. In word mode all 16 bits pass through.
- R9: Parity is odd: the used data bits plus `bus_par` must contain an odd number of ones. An accepted transfer that breaks this sets `par_err`, which then stays set until reset. The cell is still delivered.
- R10: With the output idle, the first word of a finished cell is valid in the second cycle after the edge that captures its last transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock (rising edge) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wide | input | 1 | 1 = 16-bit transfers, 0 = 8-bit transfers |
| cfg_len_sel | input | 2 | Cell length select (52/53/54 bytes) |
| bus_data | input | 16 | Transfer data |
| bus_wen_n | input | 1 | Active-low write enable |
| bus_soc | input | 1 | Start-of-cell pulse, with first transfer |
| bus_par | input | 1 | Odd parity over the used data bits |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output word |
| out_sop | output | 1 | First word of a cell |
| out_eop | output | 1 | Last word of a cell |
| irq_align | output | 1 | One-cycle alignment (runt) interrupt |
| par_err | output | 1 | Sticky parity error |

## Verification
The bench uses the default `BUF_DEPTH` of 128 entries. That is room for one committed cell draining while the next one forms, so back-to-back cells and runts run at full bus rate with no output stall. The bench sweeps all four length-select codes in both widths. Stray transfers, start pulses with the enable high, and early start pulses are mixed in at random. This covers every transfer count, including the odd 53-byte length rounded up in word mode, and rollbacks at arbitrary fill levels.

// File: rtl/cellbus_pkg.sv
package cellbus_pkg;
  localparam int unsigned BUS_W     = 16;
  localparam int unsigned MAX_BYTES = 54;
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1);

  typedef struct packed {
    logic             sop;
    logic             eop;
    logic [BUS_W-1:0] data;
  } cell_word_t;

  // Transfers per cell for a length code and bus width.
  function automatic logic [CNT_W-1:0] xfers_per_cell(input logic [1:0] len_sel,
                                                      input logic       wide);
    logic [CNT_W-1:0] nbytes;
    case (len_sel)
      2'd0:    nbytes = CNT_W'(52);
      2'd1:    nbytes = CNT_W'(53);
      default: nbytes = CNT_W'(54);
    endcase
    return wide ? CNT_W'((nbytes + CNT_W'(1)) >> 1) : nbytes;
  endfunction
endpackage

// File: rtl/cellbus_parity.sv
module cellbus_parity
  import cellbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             wide,
  input  logic [BUS_W-1:0] data,
  input  logic             par,
  output logic             par_err
);
  logic lane_ok;
  logic err_d, err_q;

  always_comb begin
    if (wide) lane_ok = ^{data, par};
    else      lane_ok = ^{data[7:0], par};
  end

  always_comb begin
    err_d = err_q | (chk_en & ~lane_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign par_err = err_q;

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9
endmodule

// File: rtl/cellbus_framer.sv
module cellbus_framer
  import cellbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic [1:0]       len_sel,
  input  logic             wen_n,
  input  logic             soc,
  input  logic [BUS_W-1:0] data,
  output logic             accept,
  output logic             wr_en,
  output cell_word_t       wr_word,
  output logic             commit,
  output logic             rollback,
  output logic             irq
);
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, target;
  logic             irq_q, irq_d;
  logic             xfer, start, cont, runt, last;

  always_comb begin
    target  = xfers_per_cell(len_sel, wide);
    xfer    = ~wen_n;
    start   = xfer & soc;
    cont    = xfer & ~soc & armed_q;
    runt    = start & armed_q;
    accept  = start | cont;
    cnt_inc = start ? CNT_W'(1) : cnt_q + CNT_W'(1);
    last    = accept & (cnt_inc == target);
  end

  // Next state
  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (last) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else begin
      armed_d = 1'b1;
      cnt_d   = cnt_inc;
    end
    irq_d = runt;
  end

  // Registers, enabled by accepted transfers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (accept) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    wr_en        = accept;
    wr_word.sop  = start;
    wr_word.eop  = last;
    wr_word.data = wide ? data : {8'h00, data[7:0]};
    commit       = last;
    rollback     = runt;
    irq          = irq_q;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q != '0) && (cnt_q < target)); // R4
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (cnt_q == '0)); // R5
  AST_WEN_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wen_n |=> $stable(cnt_q) && $stable(armed_q)); // R2
endmodule

// File: rtl/cellbus_buffer.sv
module cellbus_buffer
  import cellbus_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  cell_word_t wr_word,
  input  logic       commit,
  input  logic       rollback,
  output logic       out_valid,
  output cell_word_t out_word
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  cell_word_t      mem [DEPTH];
  logic [PW-1:0]   wr_q, wr_d, cm_q, cm_d, rd_q, rd_d, wbase;
  logic            have;
  logic            ov_q;
  cell_word_t      ow_q;

  always_comb begin
    wbase = rollback ? cm_q : wr_q;
    wr_d  = wr_en ? wbase + PW'(1) : wbase;
    cm_d  = commit ? wr_d : cm_q;
    have  = (rd_q != cm_q);
    rd_d  = have ? rd_q + PW'(1) : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      cm_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      cm_q <= cm_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wbase[AW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ow_q <= '0;
    end else begin
      ov_q <= have;
      if (have) ow_q <= mem[rd_q[AW-1:0]];
    end
  end

  assign out_valid = ov_q;
  assign out_word  = ow_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q - rd_q) < PW'(DEPTH)); // R7
  AST_COMMIT_BEHIND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_q - rd_q) <= (wr_q - rd_q)); // R7
endmodule

// File: rtl/cellbus_ingress.sv
module cellbus_ingress
  import cellbus_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wide,
  input  logic [1:0]  cfg_len_sel,
  input  logic [15:0] bus_data,
  input  logic        bus_wen_n,
  input  logic        bus_soc,
  input  logic        bus_par,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic        irq_align,
  output logic        par_err
);
  logic       accept, wr_en, commit, rollback;
  cell_word_t wr_word, out_word;

  cellbus_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (cfg_wide),
    .len_sel  (cfg_len_sel),
    .wen_n    (bus_wen_n),
    .soc      (bus_soc),
    .data     (bus_data),
    .accept   (accept),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .commit   (commit),
    .rollback (rollback),
    .irq      (irq_align)
  );

  cellbus_parity u_parity (
    .clk     (clk),
    .rst_n   (rst_n),
    .chk_en  (accept),
    .wide    (cfg_wide),
    .data    (bus_data),
    .par     (bus_par),
    .par_err (par_err)
  );

  cellbus_buffer #(.DEPTH(BUF_DEPTH)) u_buffer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_word   (wr_word),
    .commit    (commit),
    .rollback  (rollback),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  assign out_data = out_word.data;
  assign out_sop  = out_word.sop;
  assign out_eop  = out_word.eop;

  // Tracks whether the output stream is inside a cell.
  logic in_cell_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_cell_q <= 1'b0;
    else if (out_valid) in_cell_q <= ~out_eop;
  end

  AST_SOP_OUTSIDE_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> !in_cell_q); // R7
  AST_BODY_INSIDE_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> in_cell_q); // R7
  AST_CELL_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |=> out_valid); // R7
endmodule

// File: tb/cellbus_ingress_bench.sv
module cellbus_ingress_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wide;
  logic [1:0]  cfg_len_sel;
  logic [15:0] bus_data;
  logic        bus_wen_n, bus_soc, bus_par;
  logic        out_valid, out_sop, out_eop, irq_align, par_err;
  logic [15:0] out_data;

  cellbus_ingress u_cellbus_ingress (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_len_sel(cfg_len_sel),
    .bus_data(bus_data), .bus_wen_n(bus_wen_n), .bus_soc(bus_soc), .bus_par(bus_par),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .irq_align(irq_align), .par_err(par_err)
  );

  always #10 clk = ~clk;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  // Model state
  logic [17:0] pend [$];
  logic [17:0] expq [$];
  bit          m_armed = 1'b0;
  int          m_cnt   = 0;
  bit          exp_par = 1'b0;
  int          cells_done = 0;

  function automatic int exp_xfers(input logic [1:0] sel, input logic wide);
    int b;
    b = (sel == 2'd0) ? 52 : (sel == 2'd1) ? 53 : 54;
    return wide ? (b + 1) / 2 : b;
  endfunction

  function automatic logic good_par(input logic [15:0] d, input logic wide);
    return wide ? ~^d : ~^d[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // One bus cycle: drive at negedge, update the model, check after the edge.
  task automatic cyc(input logic soc, input logic wen_n, input logic [15:0] d,
                     input bit bad_par);
    bit runt_exp = 1'b0;
    bit acc = 1'b0;
    logic [15:0] md;
    bus_soc   = soc;
    bus_wen_n = wen_n;
    bus_data  = d;
    bus_par   = good_par(d, cfg_wide) ^ bad_par;
    md = cfg_wide ? d : {8'h00, d[7:0]};          // R8
    if (!wen_n) begin                              // R2
      if (soc) begin
        if (m_armed) runt_exp = 1'b1;              // R6
        pend.delete();
        pend.push_back({1'b1, 1'b0, md});
        m_cnt = 1; m_armed = 1'b1; acc = 1'b1;
      end else if (m_armed) begin                  // R3 / R5
        pend.push_back({1'b0, 1'b0, md});
        m_cnt++; acc = 1'b1;
      end
      if (acc && bad_par) exp_par = 1'b1;          // R9
      if (acc && m_cnt == exp_xfers(cfg_len_sel, cfg_wide)) begin  // R4
        pend[pend.size()-1][16] = 1'b1;
        foreach (pend[i]) expq.push_back(pend[i]);
        pend.delete();
        m_armed = 1'b0; m_cnt = 0; cells_done++;
      end
    end
    @(negedge clk);
    chk(irq_align == runt_exp, "R6", "irq_align", irq_align, runt_exp);
    chk(par_err == exp_par, "R9", "par_err", par_err, exp_par);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 16'($urandom), 1'b0);
  endtask

  // Output monitor: compare every output word with the model queue (R7).
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7", "unexpected output word", {out_sop, out_eop, out_data}, 0);
      end else begin
        logic [17:0] e;
        e = expq.pop_front();
        chk({out_sop, out_eop, out_data} == e, "R7", "output word",
            {out_sop, out_eop, out_data}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_wide = 1'b0; cfg_len_sel = 2'd0;
    bus_data = '0; bus_wen_n = 1'b1; bus_soc = 1'b0; bus_par = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && irq_align == 0 && par_err == 0, "R1", "outputs in reset",
        {out_valid, irq_align, par_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && irq_align == 0 && par_err == 0, "R1", "outputs after release",
        {out_valid, irq_align, par_err}, 0);

    // R3: stray transfers with no open cell are dropped
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 16'($urandom), 1'b0);
    // R2/R8: byte mode cell with gaps, start pulses with enable high, junk upper byte
    cyc(1'b1, 1'b1, 16'hFFFF, 1'b0);
    cyc(1'b1, 1'b0, 16'hA501, 1'b0);
    for (int i = 1; i < 52; i++) begin
      if (i % 7 == 0) cyc(1'b0, 1'b1, 16'($urandom), 1'b1);
      cyc(1'b0, 1'b0, 16'($urandom), 1'b0);
    end
    // R5: extra transfers after the cell is full are dropped
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 16'($urandom), 1'b0);
    idle(80);

    // R10: latency of a finished cell with the output idle
    cfg_wide = 1'b1; cfg_len_sel = 2'd1;
    cyc(1'b1, 1'b0, 16'h1234, 1'b0);
    for (int i = 1; i < 27; i++) cyc(1'b0, 1'b0, 16'($urandom), 1'b0);
    chk(out_valid == 0, "R10", "out_valid one cycle after last", out_valid, 0);
    idle(1);
    chk(out_valid == 1 && out_sop == 1, "R10", "first word two cycles after last",
        {out_valid, out_sop}, 2'b11);
    idle(40);

    // R6: early start pulse in word mode, new cell keeps its first word
    cfg_len_sel = 2'd2;
    cyc(1'b1, 1'b0, 16'h0BAD, 1'b0);
    for (int i = 1; i < 10; i++) cyc(1'b0, 1'b0, 16'($urandom), 1'b0);
    cyc(1'b1, 1'b0, 16'hC0DE, 1'b0);
    cyc(1'b1, 1'b0, 16'hBEEF, 1'b0);               // immediate second runt
    for (int i = 1; i < 27; i++) cyc(1'b0, 1'b0, 16'($urandom), 1'b0);
    idle(40);

    // Random sweep over every length code and both widths (R4)
    for (int w = 0; w < 2; w++) begin
      for (int s = 0; s < 4; s++) begin
        int target_cells;
        cfg_wide = w[0]; cfg_len_sel = s[1:0];
        target_cells = cells_done + 5;
        while (cells_done < target_cells) begin
          int r;
          r = $urandom % 100;
          if (!m_armed) begin
            if (r < 50)      cyc(1'b1, 1'b0, 16'($urandom), 1'b0);
            else if (r < 75) cyc(1'b0, 1'b0, 16'($urandom), 1'b0);
            else             cyc(1'b1, 1'b1, 16'($urandom), 1'b0);
          end else begin
            if (r < 2)       cyc(1'b1, 1'b0, 16'($urandom), 1'b0);
            else if (r < 5)  cyc(1'b1, 1'b1, 16'($urandom), 1'b0);
            else if (r < 20) cyc(1'b0, 1'b1, 16'($urandom), 1'b0);
            else             cyc(1'b0, 1'b0, 16'($urandom), 1'b0);
          end
        end
      end
    end
    idle(80);

    // R9: parity error is sticky and the cell is still delivered
    cfg_wide = 1'b0; cfg_len_sel = 2'd1;
    cyc(1'b1, 1'b0, 16'h0033, 1'b0);
    cyc(1'b0, 1'b1, 16'h0001, 1'b1);               // ignored, no error (R2)
    cyc(1'b0, 1'b0, 16'h0077, 1'b1);               // real error
    for (int i = 2; i < 53; i++) cyc(1'b0, 1'b0, 16'($urandom), 1'b0);
    idle(120);
    chk(expq.size() == 0, "R7", "cells left undelivered", expq.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule